// File: doc/BRIEF.md
# Cascadable BCD Counter Stage

This block is one decimal digit of a synchronous counter. It holds a 4-bit value that steps through 0 to 9 on rising clock edges and then rolls back to 0. A parallel data bus lets the stage be preset. An active-low clear forces it to zero. A parameter chooses whether the clear waits for a clock edge or acts at once.

The stage has two count enables. Both must be high for the value to advance. Only the chain enable `en_t` takes part in the terminal-count output. `tc_out` is high while the digit is 9 and `en_t` is high. It is combinational, so it can feed the `en_t` of the next, more significant stage. The parallel enable `en_p` is shared by all stages. With this wiring a chain of stages counts in decimal.

Each clock edge selects one operation, in this priority order:
- CLEAR: clear low. The value goes to 0.
- LOAD: load low. The value is taken from the data bus.
- STEP: both enables high. The value goes from n to n+1, or to 0 after 9.
- HOLD: the value is unchanged.

Top module: `bcd_stage`

## Requirements
- R1: With clear low, `q` becomes 0000. When ASYNC_CLR=0 this happens at the next rising edge and not before. When ASYNC_CLR=1 it happens at once, without a clock edge.
- R2: With clear high and load low, `q` takes `din` at the next rising edge, whatever the enables are.
- R3: With clear and load high and both enables high, `q` goes from n to n+1 at the next rising edge, for n from 0 to 8.
- R4: A STEP from the terminal value 1001 gives 0000.
- R5: With `en_p` low and no clear or load, `q` holds its value.
- R6: With `en_t` low and no clear or load, `q` holds its value and `tc_out` is 0.
- R7: `tc_out` is 1 exactly when `q` is 1001 and `en_t` is 1, with no clock delay. `en_p` has no effect on it.
- R8: A loaded value from 1010 to 1111 stays until the next operation. A STEP from any such value gives 0000.
- R9: Clear overrides load, and load overrides counting.
- R10: When two stages share `en_p` and the lower stage's `tc_out` drives the upper stage's `en_t`, the pair counts 00 to 99 in decimal and wraps to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Rising edge active. |
| clr_n | input | 1 | Clear, active low. Synchronous or asynchronous, set by ASYNC_CLR. |
| ld_n | input | 1 | Parallel load, active low, synchronous. |
| din | input | DIGIT_W | Preset value used by a load. |
| en_p | input | 1 | Count enable. Does not affect the carry. |
| en_t | input | 1 | Count enable that also gates `tc_out`. |
| q | output | DIGIT_W | Current digit. |
| tc_out | output | 1 | Terminal count: `q` is 9 and `en_t` is high. |

## Verification
The bench targets these corner cases:
- Wrap from 9 to 0. A design that let a binary carry through would show 1010 here.
- Carry while `en_p` is low. A design that gated `tc_out` with both enables would drop the carry.
- Step from loaded values above 9. A design that simply increments would reach 1101 or roll to 0000 only from 1111.
- Priority and clear timing. A swapped priority would load under clear. A clear of the wrong variant would zero the sync stage between edges, or leave the async stage waiting for an edge.
- Two-stage chain. It exposes an upper digit that steps on every edge, or that misses the 99 to 00 rollover.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } bcd_op_e;
endpackage

// File: rtl/bcd_op_sel.sv
`timescale 1ns/1ps
module bcd_op_sel
    import bcd_pkg::*;
(
    input  logic    clr_n,
    input  logic    ld_n,
    input  logic    en_p,
    input  logic    en_t,
    output bcd_op_e op
);
    // fixed priority: clear, then load, then step, else hold
    always_comb begin
        if (!clr_n)
            op = OP_CLEAR;
        else if (!ld_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/bcd_next.sv
`timescale 1ns/1ps
module bcd_next
    import bcd_pkg::*;
#(
    parameter int DIGIT_W  = 4,
    parameter int LAST_VAL = 9
) (
    input  logic [DIGIT_W-1:0] cur,
    input  logic [DIGIT_W-1:0] din,
    input  bcd_op_e            op,
    output logic [DIGIT_W-1:0] nxt
);
    localparam logic [DIGIT_W-1:0] LAST_Q = DIGIT_W'(LAST_VAL);

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            // the terminal value and any illegal value roll to zero
            OP_STEP:  nxt = (cur >= LAST_Q) ? '0 : cur + DIGIT_W'(1);
            OP_HOLD:  nxt = cur;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/bcd_carry.sv
`timescale 1ns/1ps
module bcd_carry #(
    parameter int DIGIT_W  = 4,
    parameter int LAST_VAL = 9
) (
    input  logic [DIGIT_W-1:0] cur,
    input  logic               en_t,
    output logic               tc
);
    localparam logic [DIGIT_W-1:0] LAST_Q = DIGIT_W'(LAST_VAL);

    // combinational, so it can drive the next stage's en_t
    assign tc = en_t && (cur == LAST_Q);
endmodule

// File: rtl/bcd_stage.sv
`timescale 1ns/1ps
module bcd_stage
    import bcd_pkg::*;
#(
    parameter int DIGIT_W   = 4,
    parameter int LAST_VAL  = 9,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               ld_n,
    input  logic [DIGIT_W-1:0] din,
    input  logic               en_p,
    input  logic               en_t,
    output logic [DIGIT_W-1:0] q,
    output logic               tc_out
);
    localparam logic [DIGIT_W-1:0] LAST_Q = DIGIT_W'(LAST_VAL);

    bcd_op_e            op;
    logic [DIGIT_W-1:0] cnt_q;
    logic [DIGIT_W-1:0] cnt_d;

    bcd_op_sel u_sel (
        .clr_n (clr_n),
        .ld_n  (ld_n),
        .en_p  (en_p),
        .en_t  (en_t),
        .op    (op)
    );

    bcd_next #(.DIGIT_W(DIGIT_W), .LAST_VAL(LAST_VAL)) u_next (
        .cur (cnt_q),
        .din (din),
        .op  (op),
        .nxt (cnt_d)
    );

    // state register; the clear variant is picked by parameter
    generate
        if (ASYNC_CLR) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_d;
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                cnt_q <= cnt_d;
            end
        end
    endgenerate

    bcd_carry #(.DIGIT_W(DIGIT_W), .LAST_VAL(LAST_VAL)) u_carry (
        .cur  (cnt_q),
        .en_t (en_t),
        .tc   (tc_out)
    );

    assign q = cnt_q;

    // ---------------- assertions ----------------
    logic chk_started = 1'b0;
    always_ff @(posedge clk) chk_started <= 1'b1;

    p_clear_r1: assert property (@(posedge clk)
        (chk_started && $past(!clr_n)) |-> (cnt_q == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        !ld_n |=> (cnt_q == $past(din)));

    p_step_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && en_p && en_t && cnt_q < LAST_Q) |=> (cnt_q == $past(cnt_q) + DIGIT_W'(1)));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && en_p && en_t && cnt_q >= LAST_Q) |=> (cnt_q == '0));

    p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && !(en_p && en_t)) |=> $stable(cnt_q));

    p_no_carry_r6: assert property (@(posedge clk) disable iff (!clr_n)
        !en_t |-> !tc_out);

    p_carry_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (en_t && cnt_q == LAST_Q) |-> tc_out);
endmodule

// File: tb/bcd_stage_test.sv
`timescale 1ns/1ps
module bcd_stage_test;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] q, q_hi;
    logic       tc_out, tc_hi;
    logic       a_clr_n = 1'b0, a_ld_n = 1'b1;
    logic [3:0] a_din = 4'd0, a_q;
    logic       a_tc;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bcd_stage uut (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q), .tc_out(tc_out));

    // upper digit of a two-stage chain (R10)
    bcd_stage uut_hi (
        .clk(clk), .clr_n(clr_n), .ld_n(1'b1), .din(4'd0),
        .en_p(en_p), .en_t(tc_out), .q(q_hi), .tc_out(tc_hi));

    bcd_stage #(.ASYNC_CLR(1'b1)) uut_async (
        .clk(clk), .clr_n(a_clr_n), .ld_n(a_ld_n), .din(a_din),
        .en_p(1'b0), .en_t(1'b0), .q(a_q), .tc_out(a_tc));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // move 1 ns past the next rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_clear();
        clr_n = 0; ld_n = 1; en_p = 1; en_t = 1;
        step();
        check("R1 sync clear", q, 0);
        check("R1 carry after clear", tc_out, 0);
    endtask

    task automatic t_count();
        clr_n = 1; ld_n = 1; en_p = 1; en_t = 1;
        for (int i = 1; i <= 9; i++) begin
            step();
            check("R3 step", q, i);
        end
        check("R7 carry at 9", tc_out, 1);
        step();
        check("R4 wrap", q, 0);
        check("R7 carry at 0", tc_out, 0);
    endtask

    task automatic t_enables();
        ld_n = 0; din = 4'd9; step(); ld_n = 1;
        en_p = 0; en_t = 1; #0.5;
        check("R7 carry with en_p low", tc_out, 1);
        step();
        check("R5 hold en_p low", q, 9);
        en_p = 1; en_t = 0; #0.5;
        check("R6 carry gated", tc_out, 0);
        step();
        check("R6 hold en_t low", q, 9);
    endtask

    task automatic t_load();
        en_p = 1; en_t = 1; ld_n = 0; din = 4'd5;
        step();
        check("R2 load beats count", q, 5);
        en_p = 0; en_t = 0; din = 4'd3;
        step();
        check("R2 load enables low", q, 3);
        ld_n = 1;
    endtask

    task automatic t_illegal();
        ld_n = 0; din = 4'd12; step(); ld_n = 1;
        check("R8 load 12", q, 12);
        en_p = 1; en_t = 1; #0.5;
        check("R8 no carry at 12", tc_out, 0);
        step();
        check("R8 step from 12", q, 0);
        ld_n = 0; din = 4'd15; step(); ld_n = 1;
        en_p = 0; step();
        check("R8 hold 15", q, 15);
        en_p = 1; step();
        check("R8 step from 15", q, 0);
    endtask

    task automatic t_priority();
        ld_n = 0; din = 4'd4; step();
        clr_n = 0; din = 4'd7; step();
        check("R9 clear over load", q, 0);
        clr_n = 1; ld_n = 1;
    endtask

    task automatic t_clear_timing();
        en_p = 1; en_t = 1; ld_n = 0; din = 4'd6; step(); ld_n = 1;
        en_p = 0;
        #1 clr_n = 0; #0.5;
        check("R1 sync waits for edge", q, 6);
        step();
        check("R1 sync clears at edge", q, 0);
        clr_n = 1;
        a_clr_n = 1; a_ld_n = 0; a_din = 4'd6; step(); a_ld_n = 1;
        check("R2 async stage load", a_q, 6);
        #1 a_clr_n = 0; #0.5;
        check("R1 async clears at once", a_q, 0);
        step();
        a_clr_n = 1;
    endtask

    task automatic t_cascade();
        clr_n = 0; ld_n = 1; step();
        clr_n = 1; en_p = 1; en_t = 1;
        for (int n = 1; n <= 100; n++) begin
            step();
            if (n == 37 || n == 99 || n == 100)
                check("R10 cascade", q_hi * 10 + q, n % 100);
        end
        check("R10 upper carry", tc_hi, 0);
    endtask

    initial begin
        #1;
        check("R1 reset state", q, 0);
        t_clear();
        t_count();
        t_enables();
        t_load();
        t_illegal();
        t_priority();
        t_clear_timing();
        t_cascade();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule